// File: doc/BRIEF.md
# Block SAD Accumulator with Logarithmic Fold

This block scores how well a candidate reference block matches a source block during motion estimation. It takes the sum of absolute differences (SAD) over every pixel pair of the block. One row arrives per cycle as two vectors of 8-bit pixels, one source and one reference, together with a lane mask and first-row and last-row flags. Block width is set at run time through the lane mask, up to the `LANES` parameter (16 by default). Block height is set by the flags, up to `MAX_ROWS` (16 by default).

The work is split into two phases. In the vertical phase, each lane forms its absolute difference as the larger of the two unsigned saturating subtractions. Lanes are summed in contiguous groups of eight, and each group partial is added into its own group accumulator row after row. When the last row arrives, the group accumulators enter a pipelined pairwise fold tree of log2(groups) stages, and the scalar SAD comes out with a one-cycle valid strobe. Because the fold is a pipeline, the next block may start in the cycle after the last row of the previous one.

The vertical phase is controlled by a two-state machine. In `VS_IDLE`, rows without the first flag are dropped. The named transitions are:
- T_IDLE_START: a first row without the last flag moves to `VS_ACCUM`.
- T_IDLE_SINGLE: a row flagged both first and last stays in `VS_IDLE` and emits a result.
- T_ACCUM_ROW: a plain row stays in `VS_ACCUM`.
- T_ACCUM_RESTART: a first row stays in `VS_ACCUM` and discards the sum so far.
- T_ACCUM_END: a last row returns to `VS_IDLE`.

Top module: `sad_block_fold`

## Requirements
- R1: `sad_value` equals the sum over all accepted rows of the block and all enabled lanes of |src-ref|. It is `SUM_W` bits wide (16 by default) and never overflows for blocks of up to `MAX_ROWS` rows of `LANES` lanes (largest value 255*16*16 = 65280).
- R2: The per-lane difference is symmetric and covers the full range: a source of 255 against a reference of 0 and the reverse both give 255. Lane i occupies bits [8i+7:8i] of `src_row` and `ref_row`.
- R3: A lane whose `row_mask` bit i is 0 contributes zero for that row, whatever its pixels are.
- R4: Lanes 8g to 8g+7 form group g. Group partials are accumulated across rows independently of one another before the fold, so differences placed in any single group are counted in full.
- R5: A row with `row_valid` and `row_first` clears the accumulation and starts a new block, also in the middle of a block. Rows before it are discarded.
- R6: A row with `row_valid` and `row_last`, accepted in a block, ends it. A row that carries both flags is a complete one-row block.
- R7: Rows presented with `row_valid` while idle and without `row_first` are ignored and produce no result. Cycles with `row_valid` low contribute nothing.
- R8: `sad_valid` is a one-cycle pulse exactly log2(LANES/8) cycles after the cycle in which the last row is presented (one cycle with the defaults). It pulses at no other time.
- R9: A new block may begin in the cycle right after a last row, and both results are correct.
- R10: While `rst_n` is low and after it is released, `sad_valid` is low and the block is idle. A block cut by reset produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| row_valid | input | 1 | A row is presented this cycle |
| row_first | input | 1 | The row is the first of a block |
| row_last | input | 1 | The row is the last of a block |
| row_mask | input | LANES | Per-lane enable; 0 drops the lane |
| src_row | input | 8*LANES | Source pixels, lane i at [8i+7:8i] |
| ref_row | input | 8*LANES | Reference pixels, lane i at [8i+7:8i] |
| sad_valid | output | 1 | Result strobe |
| sad_value | output | SUM_W | Block SAD |

## Verification
The hardest situation to reach from the ports is overlap: a fold still in progress while the next block's first row is already being accepted and its accumulators cleared. The sweep over all heights and six pixel patterns therefore alternates between back-to-back blocks and blocks separated by an idle cycle. Further sequences cover a restart in mid-block, rows offered while idle, and a reset in the middle of a block. The expected result and its arrival cycle come from a plain arithmetic model in the bench.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int PIX_W       = 8;
    localparam int GROUP_LANES = 8;
    localparam int PIX_MAX     = (1 << PIX_W) - 1;

    typedef enum logic [0:0] {
        VS_IDLE  = 1'b0,
        VS_ACCUM = 1'b1
    } vstate_e;
endpackage

// File: rtl/sad_lane_absdiff.sv
module sad_lane_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    output logic [PIX_W-1:0] diff
);
    logic [PIX_W-1:0] sat_ab;
    logic [PIX_W-1:0] sat_ba;

    // Two unsigned saturating subtractions; the larger one is |a-b|.
    always_comb begin
        sat_ab = (pix_a > pix_b) ? (pix_a - pix_b) : '0;
        sat_ba = (pix_b > pix_a) ? (pix_b - pix_a) : '0;
        diff   = (sat_ab > sat_ba) ? sat_ab : sat_ba;
    end
endmodule

// File: rtl/sad_group_adder.sv
module sad_group_adder #(
    parameter int N_LANES = 8,
    parameter int PIX_W   = 8,
    parameter int OUT_W   = 11
) (
    input  logic [N_LANES*PIX_W-1:0] diffs,
    input  logic [N_LANES-1:0]       lane_en,
    output logic [OUT_W-1:0]         partial
);
    always_comb begin
        partial = '0;
        for (int i = 0; i < N_LANES; i++) begin
            if (lane_en[i]) begin
                partial = partial + OUT_W'(diffs[i*PIX_W +: PIX_W]);
            end
        end
    end
endmodule

// File: rtl/sad_vert_ctrl.sv
module sad_vert_ctrl
    import sad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic row_valid,
    input  logic row_first,
    input  logic row_last,
    output logic accept,
    output logic clear,
    output logic finish,
    output logic in_block
);
    vstate_e state_q;
    vstate_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE: begin
                // T_IDLE_START; T_IDLE_SINGLE keeps VS_IDLE
                if (row_valid && row_first && !row_last) begin
                    state_d = VS_ACCUM;
                end
            end
            VS_ACCUM: begin
                // T_ACCUM_END; T_ACCUM_ROW and T_ACCUM_RESTART keep VS_ACCUM
                if (row_valid && row_last) begin
                    state_d = VS_IDLE;
                end
            end
            default: state_d = VS_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        accept   = 1'b0;
        clear    = 1'b0;
        in_block = 1'b0;
        unique case (state_q)
            VS_IDLE: begin
                accept = row_valid && row_first;
                clear  = row_valid && row_first;
            end
            VS_ACCUM: begin
                accept   = row_valid;
                clear    = row_valid && row_first;
                in_block = 1'b1;
            end
            default: ;
        endcase
        finish = accept && row_last;
    end
endmodule

// File: rtl/sad_fold_stage.sv
module sad_fold_stage #(
    parameter int N_IN = 2,
    parameter int W    = 16,
    localparam int N_OUT = N_IN / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_IN*W-1:0] in_vals,
    output logic              out_valid,
    output logic [N_OUT*W-1:0] out_vals
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vals  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                for (int i = 0; i < N_OUT; i++) begin
                    out_vals[i*W +: W] <= in_vals[(2*i)*W +: W] + in_vals[(2*i+1)*W +: W];
                end
            end
        end
    end
endmodule

// File: rtl/sad_block_fold.sv
module sad_block_fold
    import sad_pkg::*;
#(
    parameter int LANES    = 16,
    parameter int MAX_ROWS = 16,
    localparam int SUM_W   = $clog2(PIX_MAX * LANES * MAX_ROWS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   row_valid,
    input  logic                   row_first,
    input  logic                   row_last,
    input  logic [LANES-1:0]       row_mask,
    input  logic [LANES*PIX_W-1:0] src_row,
    input  logic [LANES*PIX_W-1:0] ref_row,
    output logic                   sad_valid,
    output logic [SUM_W-1:0]       sad_value
);
    localparam int NGRP        = LANES / GROUP_LANES;
    localparam int FOLD_STAGES = $clog2(NGRP);
    localparam int GSUM_W      = $clog2(PIX_MAX * GROUP_LANES + 1);

    logic accept, clear, finish, in_block;

    sad_vert_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_valid(row_valid),
        .row_first(row_first),
        .row_last (row_last),
        .accept   (accept),
        .clear    (clear),
        .finish   (finish),
        .in_block (in_block)
    );

    // Per-lane absolute differences.
    logic [LANES*PIX_W-1:0] lane_diff;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sad_lane_absdiff #(.PIX_W(PIX_W)) i_absdiff (
            .pix_a(src_row[l*PIX_W +: PIX_W]),
            .pix_b(ref_row[l*PIX_W +: PIX_W]),
            .diff (lane_diff[l*PIX_W +: PIX_W])
        );
    end

    // Group partials and vertical accumulators.
    logic [NGRP*SUM_W-1:0] acc_next_flat;
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GSUM_W-1:0] partial;
        logic [SUM_W-1:0]  acc_q;
        logic [SUM_W-1:0]  acc_next;

        sad_group_adder #(
            .N_LANES(GROUP_LANES),
            .PIX_W  (PIX_W),
            .OUT_W  (GSUM_W)
        ) i_gadd (
            .diffs  (lane_diff[g*GROUP_LANES*PIX_W +: GROUP_LANES*PIX_W]),
            .lane_en(row_mask[g*GROUP_LANES +: GROUP_LANES]),
            .partial(partial)
        );

        assign acc_next = (clear ? '0 : acc_q) + SUM_W'(partial);
        assign acc_next_flat[g*SUM_W +: SUM_W] = acc_next;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (accept) begin
                acc_q <= acc_next;
            end
        end
    end

    // Pipelined pairwise fold: stage k holds NGRP>>k values.
    logic [NGRP*SUM_W-1:0] fold_bus   [FOLD_STAGES+1];
    logic                  fold_valid [FOLD_STAGES+1];

    assign fold_bus[0]   = acc_next_flat;
    assign fold_valid[0] = finish;

    for (genvar k = 1; k <= FOLD_STAGES; k++) begin : g_fold
        localparam int N_IN  = NGRP >> (k - 1);
        localparam int N_OUT = NGRP >> k;
        logic [N_OUT*SUM_W-1:0] stage_out;

        sad_fold_stage #(.N_IN(N_IN), .W(SUM_W)) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (fold_valid[k-1]),
            .in_vals  (fold_bus[k-1][N_IN*SUM_W-1:0]),
            .out_valid(fold_valid[k]),
            .out_vals (stage_out)
        );
        assign fold_bus[k] = {{((NGRP - N_OUT)*SUM_W){1'b0}}, stage_out};
    end

    assign sad_valid = fold_valid[FOLD_STAGES];
    assign sad_value = fold_bus[FOLD_STAGES][SUM_W-1:0];
endmodule

// File: rtl/sad_block_fold_chk.sv
module sad_block_fold_chk #(
    parameter int LANES    = 16,
    parameter int MAX_ROWS = 16,
    parameter int SUM_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_valid,
    input logic             row_first,
    input logic             row_last,
    input logic             in_block,
    input logic             sad_valid,
    input logic [SUM_W-1:0] sad_value
);
    localparam int NGRP  = LANES / 8;
    localparam int LAT   = $clog2(NGRP);
    localparam int MAX_V = 255 * LANES * MAX_ROWS;

    logic ends_now;
    logic exp_valid;
    assign ends_now = row_valid && row_last && (in_block || row_first);

    if (LAT == 0) begin : g_lat0
        assign exp_valid = ends_now;
    end else begin : g_latn
        logic [LAT:0] hist;
        always_ff @(posedge clk) begin
            if (!rst_n) hist <= '0;
            else        hist <= {hist[LAT-1:0], ends_now};
        end
        assign exp_valid = hist[LAT-1];
    end

    // R8: result strobe exactly LAT cycles after a block-ending row
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid == exp_valid);

    // R1: result never exceeds the largest possible block SAD
    a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid |-> (int'(sad_value) <= MAX_V));

    // R5: a first row that is not also last opens a block
    a_r5_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_first && !row_last) |=> in_block);

    // R6: an accepted last row closes the block
    a_r6_leave: assert property (@(posedge clk) disable iff (!rst_n)
        ends_now |=> !in_block);

    // R7: rows without the first flag never open a block
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block && !(row_valid && row_first)) |=> !in_block);
endmodule

bind sad_block_fold sad_block_fold_chk #(
    .LANES   (LANES),
    .MAX_ROWS(MAX_ROWS),
    .SUM_W   (SUM_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_valid(row_valid),
    .row_first(row_first),
    .row_last (row_last),
    .in_block (in_block),
    .sad_valid(sad_valid),
    .sad_value(sad_value)
);

// File: tb/test_sad_block_fold.sv
module test_sad_block_fold;
    localparam int LANES = 16;
    localparam int LAT   = $clog2(LANES / 8);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 row_valid = 1'b0;
    logic                 row_first = 1'b0;
    logic                 row_last = 1'b0;
    logic [LANES-1:0]     row_mask = '0;
    logic [LANES*8-1:0]   src_row = '0;
    logic [LANES*8-1:0]   ref_row = '0;
    logic                 sad_valid;
    logic [15:0]          sad_value;

    sad_block_fold #(.LANES(LANES), .MAX_ROWS(16)) i_sad_block_fold (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_first(row_first),
        .row_last(row_last), .row_mask(row_mask), .src_row(src_row),
        .ref_row(ref_row), .sad_valid(sad_valid), .sad_value(sad_value)
    );

    always #5 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    done    = 1'b0;
    int    due_q[$];
    int    val_q[$];
    string tag_q[$];
    string cur_tag = "R1";
    int    m_sum = 0;
    bit    m_in  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Output monitor: compares results at their due cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                check(sad_valid && (int'(sad_value) == val_q[0]), tag_q[0],
                      sad_valid ? int'(sad_value) : -1, val_q[0]);
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end else if (sad_valid) begin
                check(1'b0, "R8 spurious strobe", int'(sad_value), -1);
            end
        end
    end

    function automatic logic [7:0] hpix(input int s, input int r, input int l);
        return 8'((s * 37 + r * 101 + l * 53 + s * r * l * 7 + (l * l) * 3) & 255);
    endfunction

    task automatic make_row(input int p, input int b, input int r,
                            output logic [LANES*8-1:0] s, output logic [LANES*8-1:0] f,
                            output logic [LANES-1:0] m);
        for (int l = 0; l < LANES; l++) begin
            m[l] = 1'b1;
            case (p)
                0: begin s[l*8 +: 8] = hpix(b, r, l); f[l*8 +: 8] = hpix(b, r, l); end
                1: begin s[l*8 +: 8] = 8'd255; f[l*8 +: 8] = 8'd0; end
                2: begin s[l*8 +: 8] = 8'd0; f[l*8 +: 8] = 8'd255; end
                3: begin s[l*8 +: 8] = hpix(b, r, l); f[l*8 +: 8] = hpix(b + 7, r, l + 3); end
                4: begin
                    s[l*8 +: 8] = hpix(b, r, l); f[l*8 +: 8] = hpix(b + 3, r + 1, l);
                    m[l] = ((l + r) % 3) != 0;
                end
                default: begin
                    s[l*8 +: 8] = hpix(b, r, l);
                    f[l*8 +: 8] = (l < 8) ? hpix(b, r, l) : hpix(b + 11, r, l);
                end
            endcase
        end
    endtask

    task automatic drive_row(input bit f, input bit l, input logic [LANES-1:0] m,
                             input logic [LANES*8-1:0] s, input logic [LANES*8-1:0] r);
        int rs;
        @(negedge clk);
        row_valid = 1'b1; row_first = f; row_last = l;
        row_mask = m; src_row = s; ref_row = r;
        rs = 0;
        for (int i = 0; i < LANES; i++) begin
            int d;
            d = int'(s[i*8 +: 8]) - int'(r[i*8 +: 8]);
            if (d < 0) d = -d;
            if (m[i]) rs += d;
        end
        if (f) begin m_sum = 0; m_in = 1'b1; end
        if (m_in) m_sum += rs;
        if (l && m_in) begin
            due_q.push_back(cyc + LAT);
            val_q.push_back(m_sum);
            tag_q.push_back(cur_tag);
            m_in = 1'b0;
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        row_valid = 1'b0; row_first = 1'b0; row_last = 1'b0;
        src_row = {LANES{8'hA5}}; ref_row = '0; row_mask = '1;
    endtask

    task automatic run_block(input int p, input int b, input int h, input int gap);
        logic [LANES*8-1:0] s, f;
        logic [LANES-1:0]   m;
        for (int r = 0; r < h; r++) begin
            make_row(p, b, r, s, f, m);
            drive_row(r == 0, r == h - 1, m, s, f);
        end
        repeat (gap) idle_cycle();
    endtask

    initial begin
        logic [LANES*8-1:0] s, f;
        logic [LANES-1:0]   m;
        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset
        check(!sad_valid, "R10 reset strobe", sad_valid, 0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!sad_valid, "R10 after reset", sad_valid, 0);
        end

        // Sweep every height with every pattern, gaps alternating.
        for (int h = 1; h <= 16; h++) begin
            for (int p = 0; p < 6; p++) begin
                int gap;
                string base;
                gap = (h + p) % 2;
                case (p)
                    0: base = "R1 equal";
                    1: base = "R2 src max";
                    2: base = "R2 ref max";
                    3: base = "R1 hash";
                    4: base = "R3 mask";
                    default: base = "R4 group1";
                endcase
                cur_tag = $sformatf("%s h=%0d%s%s/R8", base, h,
                                    (h == 1) ? "/R6" : "", (gap == 0) ? "/R9" : "");
                run_block(p, h * 13 + p, h, gap);
            end
        end
        repeat (3) idle_cycle();

        // R7: rows while idle without first flag are ignored.
        cur_tag = "R7 idle rows ignored";
        make_row(1, 0, 0, s, f, m);
        drive_row(1'b0, 1'b0, m, s, f);
        drive_row(1'b0, 1'b1, m, s, f);
        idle_cycle();
        run_block(0, 5, 2, 2);

        // R5: first flag in mid-block restarts the sum.
        cur_tag = "R5 restart";
        make_row(1, 0, 0, s, f, m);
        drive_row(1'b1, 1'b0, m, s, f);
        drive_row(1'b0, 1'b0, m, s, f);
        run_block(3, 77, 3, 2);

        // R10: a block cut by reset yields nothing.
        make_row(2, 0, 0, s, f, m);
        drive_row(1'b1, 1'b0, m, s, f);
        @(negedge clk);
        rst_n = 1'b0; row_valid = 1'b0; row_first = 1'b0; row_last = 1'b0;
        m_in = 1'b0;
        @(negedge clk);
        check(!sad_valid, "R10 mid-block reset", sad_valid, 0);
        rst_n = 1'b1;
        cur_tag = "R10 after mid-block reset/R7";
        drive_row(1'b0, 1'b1, m, s, f);
        run_block(3, 99, 4, 3);

        repeat (4) idle_cycle();
        check(due_q.size() == 0, "R8 results outstanding", due_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule